// File: doc/BRIEF.md
# Blocking Write-Back Line Cache

This block is a direct-mapped data cache placed between a processor port and a slower block-wide main memory. Each processor access is a single 32-bit word read or write. The cache holds it with a ready low until the access is complete. A line is four 32-bit words. Lines are allocated on both read and write misses. Modified lines are written to memory only when a new address displaces them.

A small controller with four states drives the memory port. The states are accept, tag compare, victim write-out and line refill. A dirty victim is always written out as one full 128-bit transfer before the refill read is issued. The refill installs the line clean, and the access is then retried as a hit. The processor and the memory both use a valid/ready handshake.

The default build has 1024 lines, which is 16 KB. The line count is a parameter. With the default, byte address bits 31..14 form the tag, 13..4 the index and 3..0 the offset.

Top module: `wb_cache`

## Requirements
- R1: After reset every line is invalid and clean, and `cpu_ready` and `mem_req_valid` are low. The first access to any index is therefore a miss.
- R2: Address bits 3..2 select the word, and word s occupies bits 32*s+31..32*s of a line. Address bits 1..0 are ignored. The next log2(lines) bits are the index and the remaining upper bits are the tag. A memory request address is always {tag, index, 4'b0000}.
- R3: On a read hit, `cpu_ready` is high for exactly one cycle: the cycle directly after the request is accepted. That cycle carries the addressed word on `cpu_rdata`, and no memory request is raised.
- R4: A miss whose line is invalid or clean issues exactly one 128-bit read at {request tag, index, 0}. It installs the returned line as valid and clean and then completes as a hit, returning the refilled word.
- R5: A miss whose line is valid and dirty first issues exactly one 128-bit write at {stored tag, index, 0}. The write carries the whole line, including every word modified since the refill, and finishes before the refill read is issued.
- R6: A write hit replaces only the addressed word, marks the line dirty and causes no memory traffic. The other three words keep their values.
- R7: A write miss refills the line first and then merges the written word. The line is left dirty, so a later read of that word hits and returns the written value.
- R8: Evicting a clean line produces no memory write.
- R9: While `mem_req_valid` is high and `mem_ready` is low, `mem_req_write`, `mem_req_addr` and `mem_req_wdata` stay unchanged and the request stays raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request strobe, held until `cpu_ready` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Memory request strobe |
| mem_req_write | output | 1 | 1 = line write-out, 0 = line read |
| mem_req_addr | output | 32 | Line-aligned memory address |
| mem_req_wdata | output | 128 | Victim line data |
| mem_rdata | input | 128 | Refill line data |
| mem_ready | input | 1 | Memory completion pulse |

## Verification
The bench targets the points where a write-back controller is most often wrong. It checks the order of write-out and refill on a dirty victim; a design that reads first would overwrite the victim before saving it. It checks that a clean victim produces no write; a design that ignores the dirty flag would produce a spurious write. It checks that a write hit keeps the neighbouring words; a lane-select error would corrupt them or lose the store. A sweep over every index and word of an 8-line build writes each word, evicts its line and reads it back from memory. That sweep catches a write-out address built from the request tag instead of the stored tag, and a dirty flag that is never set.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  // Controller states, binary encoded in a 2-bit register.
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_COMPARE   = 2'd1,
    ST_WRITEBACK = 2'd2,
    ST_ALLOCATE  = 2'd3
  } ctl_state_t;

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int NUM_LINES = 1024,
  parameter int TAG_W     = 18,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             mark_dirty,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag
);

  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  // Flag bits are reset so that every line starts invalid and clean.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= 1'b0;
    end else if (mark_dirty) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  // Tags need no reset: they are ignored while the valid bit is low.
  always_ff @(posedge clk) begin
    if (fill_en) tag_q[idx] <= fill_tag;
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];

  AST_DIRTY_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dirty |-> rd_valid);  // R1

  AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (rd_valid && !rd_dirty && rd_tag == $past(fill_tag)));  // R4

endmodule

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
  parameter int NUM_LINES  = 1024,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int SEL_W     = $clog2(LINE_WORDS),
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [SEL_W-1:0]  sel,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              word_we,
  input  logic [WORD_W-1:0] word_wdata,
  output logic [LINE_W-1:0] rd_line,
  output logic [WORD_W-1:0] rd_word
);

  logic [LINE_W-1:0] lines_q [NUM_LINES];
  logic [LINE_WORDS-1:0] lane_we;

  // Word s sits in bits WORD_W*s+WORD_W-1 .. WORD_W*s of a line.
  function automatic logic [WORD_W-1:0] pick_lane(input logic [LINE_W-1:0] line,
                                                  input logic [SEL_W-1:0] s);
    return line[s*WORD_W +: WORD_W];
  endfunction

  // One enable per word lane, decoded from the word select.
  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_lane
    assign lane_we[g] = word_we && (sel == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      lines_q[idx] <= fill_line;
    end else begin
      for (int w = 0; w < LINE_WORDS; w++) begin
        if (lane_we[w]) lines_q[idx][w*WORD_W +: WORD_W] <= word_wdata;
      end
    end
  end

  assign rd_line = lines_q[idx];
  assign rd_word = pick_lane(rd_line, sel);

  AST_ONE_LANE_WRITTEN: assert property (@(posedge clk)
    $onehot0(lane_we));  // R6

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 1024,
  localparam int OFF_W     = $clog2(LINE_WORDS * WORD_W / 8),
  localparam int SEL_W     = $clog2(LINE_WORDS),
  localparam int BYTE_W    = OFF_W - SEL_W,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [WORD_W-1:0] cpu_req_wdata,
  output logic              cpu_ready,
  input  logic              line_valid,
  input  logic              line_dirty,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic              mem_ready,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [IDX_W-1:0]  req_idx,
  output logic [SEL_W-1:0]  req_sel,
  output logic [TAG_W-1:0]  req_tag,
  output logic [WORD_W-1:0] req_wdata,
  output logic              ev_fill,
  output logic              ev_word_we
);

  // Address arithmetic, kept in one place.
  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [SEL_W-1:0] addr_word(input logic [ADDR_W-1:0] a);
    return a[BYTE_W +: SEL_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction

  ctl_state_t state_q, state_d;
  logic       req_write_q;

  // Named internal events, also used by the assertions.
  logic tag_match;
  logic ev_hit;
  logic ev_miss;
  logic ev_victim_dirty;
  logic ev_wb_done;
  logic ev_accept;

  // Byte-in-word address bits play no part in a word access.
  logic [BYTE_W-1:0] unused_byte_bits;
  assign unused_byte_bits = cpu_req_addr[BYTE_W-1:0];

  assign ev_accept       = (state_q == ST_IDLE) && cpu_req_valid;
  assign tag_match       = line_valid && (line_tag == req_tag);
  assign ev_hit          = (state_q == ST_COMPARE) && tag_match;
  assign ev_miss         = (state_q == ST_COMPARE) && !tag_match;
  assign ev_victim_dirty = ev_miss && line_valid && line_dirty;
  assign ev_wb_done      = (state_q == ST_WRITEBACK) && mem_ready;
  assign ev_fill         = (state_q == ST_ALLOCATE) && mem_ready;
  assign ev_word_we      = ev_hit && req_write_q;

  // Request latch: captured once when the controller leaves idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tag     <= '0;
      req_idx     <= '0;
      req_sel     <= '0;
      req_wdata   <= '0;
      req_write_q <= 1'b0;
    end else if (ev_accept) begin
      req_tag     <= addr_tag(cpu_req_addr);
      req_idx     <= addr_index(cpu_req_addr);
      req_sel     <= addr_word(cpu_req_addr);
      req_wdata   <= cpu_req_wdata;
      req_write_q <= cpu_req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (cpu_req_valid) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (tag_match)            state_d = ST_IDLE;
        else if (ev_victim_dirty) state_d = ST_WRITEBACK;
        else                      state_d = ST_ALLOCATE;
      end
      ST_WRITEBACK: if (mem_ready) state_d = ST_ALLOCATE;
      ST_ALLOCATE:  if (mem_ready) state_d = ST_COMPARE;
      default:      state_d = ST_IDLE;
    endcase
  end

  // Port outputs follow the state; the ready pulse also needs the tag result.
  assign cpu_ready     = ev_hit;
  assign mem_req_valid = (state_q == ST_WRITEBACK) || (state_q == ST_ALLOCATE);
  assign mem_req_write = (state_q == ST_WRITEBACK);
  assign mem_req_addr  = (state_q == ST_WRITEBACK) ? line_base(line_tag, req_idx)
                                                   : line_base(req_tag, req_idx);

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);  // R3

  AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req_valid);  // R3

  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITEBACK) |-> (line_valid && line_dirty));  // R5

  AST_WB_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_done |=> (mem_req_valid && !mem_req_write));  // R5

  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss && !(line_valid && line_dirty)) |=> !mem_req_write);  // R8

  AST_REFILL_RETRIES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> (state_q == ST_COMPARE && tag_match));  // R4

  AST_WRITE_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word_we |=> line_dirty);  // R6

  AST_MEM_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));  // R2

  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_ready) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr)));  // R9

endmodule

// File: rtl/wb_cache.sv
module wb_cache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 1024,
  localparam int LINE_W    = WORD_W * LINE_WORDS,
  localparam int OFF_W     = $clog2(LINE_W / 8),
  localparam int SEL_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [WORD_W-1:0] cpu_req_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ready
);

  logic             line_valid;
  logic             line_dirty;
  logic [TAG_W-1:0] line_tag;
  logic [IDX_W-1:0] req_idx;
  logic [SEL_W-1:0] req_sel;
  logic [TAG_W-1:0] req_tag;
  logic [WORD_W-1:0] req_wdata;
  logic             ev_fill;
  logic             ev_word_we;
  logic [LINE_W-1:0] line_data;

  wbc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_ready     (cpu_ready),
    .line_valid    (line_valid),
    .line_dirty    (line_dirty),
    .line_tag      (line_tag),
    .mem_ready     (mem_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .req_idx       (req_idx),
    .req_sel       (req_sel),
    .req_tag       (req_tag),
    .req_wdata     (req_wdata),
    .ev_fill       (ev_fill),
    .ev_word_we    (ev_word_we)
  );

  wbc_tag_store #(
    .NUM_LINES(NUM_LINES), .TAG_W(TAG_W)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (req_idx),
    .fill_en    (ev_fill),
    .fill_tag   (req_tag),
    .mark_dirty (ev_word_we),
    .rd_valid   (line_valid),
    .rd_dirty   (line_dirty),
    .rd_tag     (line_tag)
  );

  wbc_line_store #(
    .NUM_LINES(NUM_LINES), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)
  ) u_lines (
    .clk        (clk),
    .idx        (req_idx),
    .sel        (req_sel),
    .fill_en    (ev_fill),
    .fill_line  (mem_rdata),
    .word_we    (ev_word_we),
    .word_wdata (req_wdata),
    .rd_line    (line_data),
    .rd_word    (cpu_rdata)
  );

  assign mem_req_wdata = line_data;

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && !mem_ready) |=> $stable(mem_req_wdata));  // R9

endmodule

// File: tb/tb_wb_cache.sv
module tb_wb_cache;

  localparam int LINES = 8;
  localparam int LAT   = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req_valid = 1'b0;
  logic         cpu_req_write = 1'b0;
  logic [31:0]  cpu_req_addr = '0;
  logic [31:0]  cpu_req_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready;
  logic         mem_req_valid;
  logic         mem_req_write;
  logic [31:0]  mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  always #10 clk = ~clk;

  wb_cache #(.NUM_LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int checks = 0;
  int errors = 0;

  logic [127:0] bmem  [0:255];
  logic [31:0]  ref_w [0:255][0:3];
  bit           sh_valid [LINES];
  bit           sh_dirty [LINES];
  int           sh_tag   [LINES];

  int n_rd = 0, n_wr = 0, seq = 0, wr_seq = 0, rd_seq = 0, lat_cnt = 0;
  logic [31:0]  wr_addr = '0;
  logic [127:0] wr_data = '0;
  logic [31:0]  hold_addr = '0;
  logic [127:0] hold_wdata = '0;
  logic         hold_write = 1'b0;

  function automatic logic [31:0] pat(input int b, input int w);
    return 32'h5A00_0000 + 32'(b * 16 + w);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory model: answers after LAT cycles with a one-cycle ready pulse.
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      lat_cnt = 0;
    end else if (mem_req_valid) begin
      lat_cnt++;
      if (lat_cnt == 1) begin
        hold_addr  = mem_req_addr;
        hold_write = mem_req_write;
        hold_wdata = mem_req_wdata;
      end
      if (lat_cnt == LAT) begin
        seq++;
        chk(hold_addr == mem_req_addr && hold_write == mem_req_write &&
            (!mem_req_write || hold_wdata == mem_req_wdata),
            "R9", "request held", {96'b0, mem_req_addr}, {96'b0, hold_addr});
        chk(mem_req_addr[3:0] == 4'h0, "R2", "line aligned address",
            {124'b0, mem_req_addr[3:0]}, 128'b0);
        if (mem_req_write) begin
          n_wr++;
          wr_seq  = seq;
          wr_addr = mem_req_addr;
          wr_data = mem_req_wdata;
          bmem[mem_req_addr[11:4]] = mem_req_wdata;
        end else begin
          n_rd++;
          rd_seq = seq;
          mem_rdata = bmem[mem_req_addr[11:4]];
        end
        mem_ready = 1'b1;
      end
    end
  end

  // One processor access, checked against the bench's own cache model.
  task automatic access(input bit wr, input int blk, input int w,
                        input logic [31:0] wd, output bit was_hit);
    int idx, tg, cyc, r0, w0, dr, dw, old_blk;
    bit exp_hit, exp_wb;
    logic [127:0] exp_line;
    logic [31:0] rd;
    string rq;
    idx = blk % LINES;
    tg  = blk / LINES;
    exp_hit = sh_valid[idx] && (sh_tag[idx] == tg);
    exp_wb  = !exp_hit && sh_valid[idx] && sh_dirty[idx];
    old_blk = sh_tag[idx] * LINES + idx;
    exp_line = {ref_w[old_blk][3], ref_w[old_blk][2], ref_w[old_blk][1], ref_w[old_blk][0]};
    r0 = n_rd;
    w0 = n_wr;
    @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_write = wr;
    cpu_req_addr  = 32'(blk * 16 + w * 4 + ((blk + w) % 4));  // R2: byte bits vary
    cpu_req_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 1000);
    rd = cpu_rdata;
    chk(cpu_ready == 1'b1, "R3", "access completes", {127'b0, cpu_ready}, 128'd1);
    cpu_req_valid = 1'b0;
    cpu_req_write = 1'b0;
    dr = n_rd - r0;
    dw = n_wr - w0;
    if (exp_hit) begin
      rq = wr ? "R6" : "R3";
      chk(dr == 0 && dw == 0, rq, "no memory traffic on hit", 128'(dr + dw), 128'd0);
      chk(cyc == 1, "R3", "hit latency", 128'(cyc), 128'd1);
    end else begin
      rq = wr ? "R7" : "R4";
      chk(dr == 1, rq, "one refill read", 128'(dr), 128'd1);
      if (exp_wb) begin
        chk(dw == 1, "R5", "one victim write", 128'(dw), 128'd1);
        chk(wr_addr == 32'(old_blk * 16), "R5", "victim address",
            {96'b0, wr_addr}, 128'(old_blk * 16));
        chk(wr_data == exp_line, "R5", "victim data", wr_data, exp_line);
        chk(wr_seq < rd_seq, "R5", "write before refill", 128'(wr_seq), 128'(rd_seq));
      end else begin
        chk(dw == 0, "R8", "no write for clean victim", 128'(dw), 128'd0);
      end
    end
    if (!wr) chk(rd == ref_w[blk][w], "R2", "read word", {96'b0, rd}, {96'b0, ref_w[blk][w]});
    if (wr) ref_w[blk][w] = wd;
    sh_dirty[idx] = exp_hit ? (sh_dirty[idx] | wr) : wr;
    sh_valid[idx] = 1'b1;
    sh_tag[idx]   = tg;
    was_hit = (dr == 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seq_blk [8] = '{22, 26, 22, 26, 16, 3, 16, 18};
    bit seq_hit [8] = '{0, 0, 1, 1, 0, 0, 1, 0};
    bit h;
    for (int b = 0; b < 256; b++) begin
      for (int w = 0; w < 4; w++) begin
        ref_w[b][w] = pat(b, w);
        bmem[b][w*32 +: 32] = pat(b, w);
      end
    end
    for (int i = 0; i < LINES; i++) begin
      sh_valid[i] = 1'b0;
      sh_dirty[i] = 1'b0;
      sh_tag[i]   = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ready == 1'b0 && mem_req_valid == 1'b0, "R1", "outputs after reset",
        {126'b0, cpu_ready, mem_req_valid}, 128'd0);

    // R1/R4: fixed block sequence with known hit pattern; 18 evicts 26.
    for (int k = 0; k < 8; k++) begin
      access(1'b0, seq_blk[k], k % 4, 32'h0, h);
      chk(h == seq_hit[k], "R1", "sequence hit/miss", 128'(h), 128'(seq_hit[k]));
    end

    // R6: write hit, neighbours kept.
    access(1'b1, 18, 2, 32'hDEAD_0018, h);
    access(1'b0, 18, 2, 32'h0, h);
    access(1'b0, 18, 0, 32'h0, h);
    // R5: dirty victim written out before refill.
    access(1'b0, 26, 1, 32'h0, h);
    // R7: write miss allocates, merges and leaves the line dirty.
    access(1'b1, 5, 3, 32'hBEEF_0005, h);
    chk(h == 1'b0, "R7", "write miss refills", 128'(h), 128'd0);
    access(1'b0, 5, 3, 32'h0, h);
    chk(h == 1'b1, "R7", "merged word hits", 128'(h), 128'd1);
    access(1'b0, 13, 0, 32'h0, h);
    // R8: clean victim.
    access(1'b0, 8, 0, 32'h0, h);

    // Sweep: every index and lane written, evicted, then read back from memory.
    for (int i = 0; i < LINES; i++) begin
      for (int w = 0; w < 4; w++) access(1'b1, 32 + i, w, 32'hC000_0000 + 32'(i * 4 + w), h);
      access(1'b0, 40 + i, i % 4, 32'h0, h);
      for (int w = 0; w < 4; w++) access(1'b0, 32 + i, w, 32'h0, h);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule